// File: doc/BRIEF.md
# Halfband 2x Complex Decimator

This block halves the sample rate of a complex baseband stream. A converter that runs at twice the processing clock hands over two consecutive I/Q samples on every processing-clock cycle. The block runs them through a fixed 47-tap halfband low-pass filter and emits one filtered I/Q sample per accepted pair. It computes only the output phase that is kept. Its polyphase structure feeds the newer sample of each pair through twelve symmetric coefficient pairs, and the older sample through a single center tap.

The filter is hard-wired. Every odd-indexed tap is zero except the center, so only thirteen multiplies per rail are needed for each output. All terms are summed at full precision. The block then scales by 2^-18, rounds to nearest and saturates to the output width. The pipeline advances only on accepted pairs. Gaps in the input stream therefore give gaps in the output, and the filter phase does not slip.

Top module: `hbd_decim2`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_i`/`out_q` are 0. Reset also clears the sample history, so outputs after reset depend only on pairs accepted after reset.
- R2: Each pair accepted with `in_valid` high on a rising edge gives exactly one `out_valid` pulse, in the cycle after the fourth following rising edge. Input data presented while `in_valid` is low is ignored. Pairs may be back-to-back or separated by idle cycles.
- R3: Lane 0 (`in_*0`) carries the older full-rate sample x[2n] and lane 1 (`in_*1`) carries the newer sample x[2n+1] of pair n. Output n equals the full-rate convolution sum over k=0..46 of h[k]*x[2n+1-k], with x taken as zero before reset, then scaled and rounded as in R6.
- R4: The coefficient set is as follows. h[23] = 131071. Every other odd k has h[k] = 0. For even k = 2j with j = 0..11, the magnitudes are 62, 194, 440, 855, 1505, 2478, 3900, 5990, 9187, 14632, 26536 and 83009. Even j is negative and odd j is positive, and h[46-k] = h[k].
- R5: A single nonzero sample A on lane 0 of pair p gives exactly one nonzero output, at output index p+11, with value round(131071*A/2^18).
- R6: The output equals floor((acc + 2^17) / 2^18), where acc is the full-precision sum of R3. This rounds to nearest, with ties going toward plus infinity.
- R7: Results above 32767 give 32767 and results below -32768 give -32768 (for the default 16-bit output).
- R8: A full-rate tone at half the input rate (lane 0 = +A, lane 1 = -A) is suppressed: the settled output magnitude is at most 2 for |A| <= 30000.
- R9: A constant input A on both lanes settles to round(A*262127/2^18). For A = 20000 that is 19999, and for A = -20000 it is -19999.
- R10: The I and Q rails use the same filter and do not interact. A stimulus on one rail leaves the other at 0.
- R11: Between valid outputs, `out_i` and `out_q` hold the value of the most recent valid output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock (half the converter rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the input sample pair |
| in_i0 | input | IN_W | I component of the older sample of the pair |
| in_i1 | input | IN_W | I component of the newer sample of the pair |
| in_q0 | input | IN_W | Q component of the older sample of the pair |
| in_q1 | input | IN_W | Q component of the newer sample of the pair |
| out_valid | output | 1 | Qualifies the decimated output sample |
| out_i | output | OUT_W | Decimated, rounded, saturated I sample |
| out_q | output | OUT_W | Decimated, rounded, saturated Q sample |

## Verification
In one cycle the block can accept a new pair while it emits the result of a pair accepted four edges earlier. When the input has idle cycles, those two events fall out of step. The table segments mix back-to-back pairs with pairs separated by two idle cycles, and they drive junk data while `in_valid` is low. Each cycle, the observed `out_valid` is compared with the `in_valid` applied five sampling points earlier, and each emitted value is compared with a full-rate convolution computed over only the accepted samples. A slipped phase or a captured idle sample therefore shows up as a wrong value at a known output index.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    // coefficient word and filter geometry
    localparam int COEF_W     = 18;
    localparam int SIDE_TAPS  = 12;                 // distinct nonzero side coefficients
    localparam int ODD_DEPTH  = 2 * SIDE_TAPS;      // newer-lane history length
    localparam int EVEN_DEPTH = SIDE_TAPS;          // older-lane delay to reach center
    localparam int SCALE_SHIFT = COEF_W;            // unity gain scaling

    localparam logic signed [COEF_W-1:0] CENTER_COEF = 18'sd131071;

    // side coefficient j multiplies full-rate taps 2j and 46-2j
    function automatic logic signed [COEF_W-1:0] side_coef(input int j);
        int mag;
        case (j)
            0:       mag = 62;
            1:       mag = 194;
            2:       mag = 440;
            3:       mag = 855;
            4:       mag = 1505;
            5:       mag = 2478;
            6:       mag = 3900;
            7:       mag = 5990;
            8:       mag = 9187;
            9:       mag = 14632;
            10:      mag = 26536;
            11:      mag = 83009;
            default: mag = 0;
        endcase
        if ((j % 2) == 0) begin
            mag = -mag;
        end
        return COEF_W'(mag);
    endfunction

endpackage

// File: rtl/hbd_tap_line.sv
module hbd_tap_line #(
    parameter int W     = 16,
    parameter int DEPTH = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] taps [DEPTH]
);

    // taps[0] is the newest accepted sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                taps[s] <= '0;
            end
        end else if (shift_en) begin
            taps[0] <= din;
            for (int s = 1; s < DEPTH; s++) begin
                taps[s] <= taps[s-1];
            end
        end
    end

endmodule

// File: rtl/hbd_sym_mac.sv
module hbd_sym_mac #(
    parameter int IN_W   = 16,
    parameter int COEF_W = 18,
    parameter logic signed [COEF_W-1:0] COEF = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pre_en,
    input  logic                          mul_en,
    input  logic signed [IN_W-1:0]        near_s,
    input  logic signed [IN_W-1:0]        far_s,
    output logic signed [IN_W+COEF_W:0]   prod
);

    localparam int PRE_W  = IN_W + 1;
    localparam int PROD_W = PRE_W + COEF_W;

    logic signed [PRE_W-1:0] pre_r;

    // symmetric pair folded before the multiply
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_r <= '0;
            prod  <= '0;
        end else begin
            if (pre_en) begin
                pre_r <= PRE_W'(near_s) + PRE_W'(far_s);
            end
            if (mul_en) begin
                prod <= PROD_W'(pre_r) * PROD_W'(COEF);
            end
        end
    end

endmodule

// File: rtl/hbd_round_sat.sv
module hbd_round_sat #(
    parameter int ACC_W = 38,
    parameter int SHIFT = 18,
    parameter int OUT_W = 16
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] y
);

    localparam logic signed [ACC_W-1:0] HALF_LSB =
        $signed({{(ACC_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}});
    localparam logic signed [ACC_W-1:0] POS_LIM =
        $signed({{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
    localparam logic signed [ACC_W-1:0] NEG_LIM =
        $signed({{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}});

    logic signed [ACC_W-1:0] biased;
    logic signed [ACC_W-1:0] scaled;

    always_comb begin
        biased = acc + HALF_LSB;
        scaled = biased >>> SHIFT;
        if (scaled > POS_LIM) begin
            y = POS_LIM[OUT_W-1:0];
        end else if (scaled < NEG_LIM) begin
            y = NEG_LIM[OUT_W-1:0];
        end else begin
            y = scaled[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/hbd_rail.sv
module hbd_rail
    import hbd_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic                    pre_en,
    input  logic                    mul_en,
    input  logic                    acc_en,
    input  logic                    out_en,
    input  logic signed [IN_W-1:0]  even_in,
    input  logic signed [IN_W-1:0]  odd_in,
    output logic signed [OUT_W-1:0] y
);

    localparam int PROD_W = IN_W + 1 + COEF_W;
    localparam int ACC_W  = IN_W + COEF_W + 4;

    logic signed [IN_W-1:0]   odd_taps [ODD_DEPTH];
    logic signed [IN_W-1:0]   even_q   [EVEN_DEPTH];
    logic signed [PROD_W-1:0] prod     [SIDE_TAPS];
    logic signed [IN_W-1:0]   center_r;
    logic signed [PROD_W-1:0] center_p;
    logic signed [ACC_W-1:0]  acc_d;
    logic signed [ACC_W-1:0]  acc_r;
    logic signed [OUT_W-1:0]  y_d;

    // newer-lane history feeds the folded side taps
    hbd_tap_line #(
        .W     (IN_W),
        .DEPTH (ODD_DEPTH)
    ) u_odd_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (odd_in),
        .taps     (odd_taps)
    );

    // older-lane delay aligns it with the center coefficient
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < EVEN_DEPTH; s++) begin
                even_q[s] <= '0;
            end
        end else if (shift_en) begin
            even_q[0] <= even_in;
            for (int s = 1; s < EVEN_DEPTH; s++) begin
                even_q[s] <= even_q[s-1];
            end
        end
    end

    for (genvar j = 0; j < SIDE_TAPS; j++) begin : g_side
        hbd_sym_mac #(
            .IN_W   (IN_W),
            .COEF_W (COEF_W),
            .COEF   (side_coef(j))
        ) u_mac (
            .clk    (clk),
            .rst_n  (rst_n),
            .pre_en (pre_en),
            .mul_en (mul_en),
            .near_s (odd_taps[j]),
            .far_s  (odd_taps[ODD_DEPTH-1-j]),
            .prod   (prod[j])
        );
    end

    // center path kept in step with the side-tap pipeline
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            center_r <= '0;
            center_p <= '0;
        end else begin
            if (pre_en) begin
                center_r <= even_q[EVEN_DEPTH-1];
            end
            if (mul_en) begin
                center_p <= PROD_W'(center_r) * PROD_W'(CENTER_COEF);
            end
        end
    end

    always_comb begin
        acc_d = ACC_W'(center_p);
        for (int j = 0; j < SIDE_TAPS; j++) begin
            acc_d = acc_d + ACC_W'(prod[j]);
        end
    end

    hbd_round_sat #(
        .ACC_W (ACC_W),
        .SHIFT (SCALE_SHIFT),
        .OUT_W (OUT_W)
    ) u_round (
        .acc (acc_r),
        .y   (y_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_r <= '0;
            y     <= '0;
        end else begin
            if (acc_en) begin
                acc_r <= acc_d;
            end
            if (out_en) begin
                y <= y_d;
            end
        end
    end

endmodule

// File: rtl/hbd_decim2.sv
module hbd_decim2 #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_i0,
    input  logic signed [IN_W-1:0]  in_i1,
    input  logic signed [IN_W-1:0]  in_q0,
    input  logic signed [IN_W-1:0]  in_q1,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);

    localparam int STAGES = 4;   // pre-add, multiply, sum, round
    localparam int RAILS  = 2;   // I and Q

    logic [STAGES-1:0]       vpipe;
    logic signed [IN_W-1:0]  rail_even [RAILS];
    logic signed [IN_W-1:0]  rail_odd  [RAILS];
    logic signed [OUT_W-1:0] rail_y    [RAILS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpipe     <= '0;
            out_valid <= 1'b0;
        end else begin
            vpipe     <= {vpipe[STAGES-2:0], in_valid};
            out_valid <= vpipe[STAGES-1];
        end
    end

    always_comb begin
        rail_even[0] = in_i0;
        rail_odd[0]  = in_i1;
        rail_even[1] = in_q0;
        rail_odd[1]  = in_q1;
    end

    for (genvar r = 0; r < RAILS; r++) begin : g_rail
        hbd_rail #(
            .IN_W  (IN_W),
            .OUT_W (OUT_W)
        ) u_rail (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (in_valid),
            .pre_en   (vpipe[0]),
            .mul_en   (vpipe[1]),
            .acc_en   (vpipe[2]),
            .out_en   (vpipe[3]),
            .even_in  (rail_even[r]),
            .odd_in   (rail_odd[r]),
            .y        (rail_y[r])
        );
    end

    assign out_i = rail_y[0];
    assign out_q = rail_y[1];

endmodule

// File: rtl/hbd_decim2_chk.sv
module hbd_decim2_chk #(
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_i,
    input logic signed [OUT_W-1:0] out_q
);

    // R1: first edge out of reset sees a quiet output
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && out_i == '0 && out_q == '0));

    // R2: every accepted pair yields a valid output five sampling edges on
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##5 out_valid);

    // R2: no output without an accepted pair
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##5 !out_valid);

    // R11: outputs hold between valid beats
    a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind hbd_decim2 hbd_decim2_chk #(
    .OUT_W (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
);

// File: tb/sim_hbd_decim2.sv
`timescale 1ns/1ps
module sim_hbd_decim2;

    localparam int  HIST = 1024;
    localparam time TCK  = 20ns;

    typedef struct packed {
        logic signed [15:0] i0;
        logic signed [15:0] i1;
        logic signed [15:0] q0;
        logic signed [15:0] q1;
        logic [7:0]         reps;
        logic [3:0]         gap;
    } seg_t;

    localparam int NSEG = 8;
    localparam seg_t SEGS [NSEG] = '{
        '{16'sd0,     16'sd8192,  16'sd0,      16'sd0,    8'd1,  4'd0},
        '{16'sd0,     16'sd0,     16'sd0,      16'sd0,    8'd30, 4'd0},
        '{16'sd0,     16'sd0,     -16'sd12000, 16'sd0,    8'd1,  4'd0},
        '{16'sd0,     16'sd0,     16'sd0,      16'sd0,    8'd30, 4'd1},
        '{16'sd1000,  -16'sd3000, 16'sd500,    16'sd700,  8'd10, 4'd2},
        '{16'sd0,     16'sd0,     16'sd0,      16'sd0,    8'd30, 4'd0},
        '{16'sd20000, 16'sd20000, -16'sd20000, -16'sd20000, 8'd40, 4'd0},
        '{16'sd0,     16'sd0,     16'sd0,      16'sd0,    8'd30, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_i0 = '0, in_i1 = '0, in_q0 = '0, in_q1 = '0;
    logic out_valid;
    logic signed [15:0] out_i, out_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int pairs = 0;
    int nout = 0;
    longint xi [2*HIST];
    longint xq [2*HIST];
    longint got_i [HIST];
    longint got_q [HIST];
    logic [4:0] vh = '0;
    longint last_i = 0, last_q = 0;

    always #(TCK/2) clk = ~clk;

    hbd_decim2 #(.IN_W(16), .OUT_W(16)) u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .in_i0 (in_i0), .in_i1 (in_i1), .in_q0 (in_q0), .in_q1 (in_q1),
        .out_valid (out_valid), .out_i (out_i), .out_q (out_q)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // R4 coefficient set, full-rate index k
    function automatic longint coef(input int k);
        int j;
        longint m;
        if (k == 23) return 131071;
        if (k < 0 || k > 46 || (k % 2) != 0) return 0;
        j = (k <= 22) ? k / 2 : (46 - k) / 2;
        case (j)
            0: m = 62;     1: m = 194;    2: m = 440;    3: m = 855;
            4: m = 1505;   5: m = 2478;   6: m = 3900;   7: m = 5990;
            8: m = 9187;   9: m = 14632;  10: m = 26536; default: m = 83009;
        endcase
        return ((j % 2) == 0) ? -m : m;
    endfunction

    // R6/R7 scaling, rounding and clamping
    function automatic longint rnd(input longint acc);
        longint s;
        s = (acc + 131072) >>> 18;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    // R3 full-rate reference over accepted samples only
    function automatic longint ref_out(input int n, input bit qr);
        longint acc = 0;
        for (int k = 0; k < 47; k++) begin
            int idx = 2*n + 1 - k;
            if (idx >= 0 && idx < 2*pairs) begin
                acc += coef(k) * (qr ? xq[idx] : xi[idx]);
            end
        end
        return rnd(acc);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            vh = '0; nout = 0; last_i = 0; last_q = 0;
        end else begin
            chk(out_valid === vh[4], "R2 valid timing", longint'(out_valid), longint'(vh[4]));
            if (out_valid) begin
                longint ei, eq;
                ei = ref_out(nout, 1'b0);
                eq = ref_out(nout, 1'b1);
                chk(out_i == ei, "R3 I sample", out_i, ei);
                chk(out_q == eq, "R10 Q sample", out_q, eq);
                if (nout < HIST) begin
                    got_i[nout] = out_i;
                    got_q[nout] = out_q;
                end
                nout++;
                last_i = out_i;
                last_q = out_q;
            end else begin
                chk(out_i == last_i && out_q == last_q, "R11 hold", out_i, last_i);
            end
            vh = {vh[3:0], in_valid};
        end
    end

    task automatic drive(input int a0, input int a1, input int b0, input int b1);
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_i0 = 16'(a0); in_i1 = 16'(a1);
        in_q0 = 16'(b0); in_q1 = 16'(b1);
        if (pairs < HIST) begin
            xi[2*pairs] = a0; xi[2*pairs+1] = a1;
            xq[2*pairs] = b0; xq[2*pairs+1] = b1;
        end
        pairs++;
    endtask

    // idle cycles carry junk that must be ignored (R2)
    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #2;
            in_valid = 1'b0;
            in_i0 = 16'sh5a5a; in_i1 = -16'sd7777;
            in_q0 = 16'sh1234; in_q1 = -16'sd31000;
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0;
        in_valid = 1'b0;
        pairs = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid low in reset", longint'(out_valid), 0);
        chk(out_i == 0 && out_q == 0, "R1 outputs zero in reset", out_i, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
    endtask

    initial begin
        #(TCK * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0 && out_i == 0 && out_q == 0, "R1 initial reset state", out_i, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;

        // table walk: reference model judges every output
        for (int s = 0; s < NSEG; s++) begin
            for (int r = 0; r < int'(SEGS[s].reps); r++) begin
                drive(SEGS[s].i0, SEGS[s].i1, SEGS[s].q0, SEGS[s].q1);
                if (SEGS[s].gap != 0) idle(int'(SEGS[s].gap));
            end
        end
        idle(12);
        chk(nout == pairs, "R2 one output per pair", nout, pairs);

        // reset with a full pipeline, then older-lane impulse (R1, R5, R10)
        for (int p = 0; p < 8; p++) drive(30000, -25000, 12000, 9000);
        idle(1);
        do_reset();
        drive(16384, 0, 0, 0);
        for (int p = 0; p < 29; p++) drive(0, 0, 0, 0);
        idle(12);
        chk(got_i[11] == 8192, "R5 center response", got_i[11], 8192);
        for (int n = 0; n < 30; n++) begin
            if (n != 11) chk(got_i[n] == 0, "R5 single nonzero output", got_i[n], 0);
            chk(got_q[n] == 0, "R10 idle rail stays zero", got_q[n], 0);
        end

        // newer-lane impulse traces the coefficient list (R3, R4, R6)
        do_reset();
        drive(0, -32768, 0, 32767);
        for (int p = 0; p < 29; p++) drive(0, 0, 0, 0);
        idle(12);
        chk(got_i[0] == 8, "R6 round 7.75 to 8", got_i[0], 8);
        chk(got_q[0] == -8, "R6 round -7.75 to -8", got_q[0], -8);
        chk(got_i[11] == -10376, "R4 largest side tap", got_i[11], -10376);
        chk(got_q[11] == 10376, "R4 largest side tap Q", got_q[11], 10376);
        for (int j = 0; j < 24; j++) begin
            chk(got_i[j] == rnd(coef(2*j) * -32768), "R4 impulse vs list", got_i[j], rnd(coef(2*j) * -32768));
            chk(got_i[j] == got_i[23-j], "R4 symmetry", got_i[j], got_i[23-j]);
        end
        chk(got_i[24] == 0 && got_i[25] == 0, "R3 response length", got_i[24], 0);

        // half-rate tone is in the stopband (R8)
        do_reset();
        for (int p = 0; p < 60; p++) drive(30000, -30000, -30000, 30000);
        idle(12);
        for (int n = 30; n < 60; n++) begin
            chk(got_i[n] <= 2 && got_i[n] >= -2, "R8 stopband I", got_i[n], 2);
            chk(got_q[n] <= 2 && got_q[n] >= -2, "R8 stopband Q", got_q[n], 2);
        end

        // DC passes with near-unity gain (R9)
        do_reset();
        for (int p = 0; p < 40; p++) drive(20000, 20000, -20000, -20000);
        idle(12);
        chk(got_i[35] == 19999, "R9 DC gain I", got_i[35], 19999);
        chk(got_q[35] == -19999, "R9 DC gain Q", got_q[35], -19999);

        // worst-case sign pattern drives both clamps (R7)
        do_reset();
        for (int p = 0; p < 24; p++) begin
            int sg;
            int ev;
            sg = (coef(2*(23-p)) < 0) ? -32767 : 32767;
            ev = (p == 12) ? 32767 : 0;
            drive(ev, sg, -ev, -sg);
        end
        for (int p = 0; p < 6; p++) drive(0, 0, 0, 0);
        idle(12);
        chk(got_i[23] == 32767, "R7 positive clamp", got_i[23], 32767);
        chk(got_q[23] == -32768, "R7 negative clamp", got_q[23], -32768);
        chk(nout == pairs, "R2 count after gaps", nout, pairs);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

endmodule